// File: doc/BRIEF.md
# Two-key protected write guard for a watchdog control port

This block sits between a simple register write bus and a watchdog core. It shields two registers, the control word at offset 0x00 and the clear request at offset 0x04. Every bus write is 32 bits wide. The upper byte carries a key and the lower 24 bits carry the payload. An update reaches the core only when the same payload arrives twice at the same offset. The first write must carry the opening key 0x55 and the second the confirming key 0xAA. Any other write in between throws the sequence away.

The sequencer has three states. `SEQ_IDLE` waits for an opening write. `SEQ_ARM_CTRL` and `SEQ_ARM_CLR` each hold a captured payload and wait for the confirming write.

- IDLE to ARM_CTRL: an opening write to 0x00 while the control word is not locked.
- IDLE to ARM_CLR: an opening write to 0x04.
- IDLE to IDLE: any other write, or no write.
- From either armed state to IDLE: any write. If it is the matching confirmation, that write commits.
- Either armed state stays armed on a cycle with no write.

A committed control word keeps only its defined fields. If its lock bit is set, the control word is frozen until reset. A committed clear raises a one-cycle clear pulse for the core. The read port always shows the control word with the key byte as zero. Its enable and clock-enable bits follow one cycle late, as if they came through a synchroniser, so software polls until they match.

Top module: `keyed_reg_guard`

## Requirements
- R1: After reset `ctrl_value`, `commit_data` and `rd_data` are zero, `ctrl_locked` is 0, and `commit_ctrl`, `commit_clr` and `wdt_clear` are low.
- R2: A write with key 0x55 (bits 31:24) to offset 0x00, followed by a write with key 0xAA to offset 0x00 carrying the same bits 23:0, commits. In the cycle after the second write, `ctrl_value` and `commit_data` equal that payload masked as in R9, and `commit_ctrl` is high for exactly one cycle.
- R3: The same two-key sequence at offset 0x04 pulses `commit_clr` for one cycle. `commit_data` then carries the raw payload and `wdt_clear` equals payload bit 0 during that cycle.
- R4: A single write with key 0x55 changes no output.
- R5: While armed, a write whose key is not 0xAA aborts the sequence, including a second 0x55 write. A later 0xAA write then commits nothing.
- R6: While armed, a 0xAA write to a different offset, or with a payload differing from the captured one, aborts without committing.
- R7: A 0xAA write with no sequence armed is ignored.
- R8: Committing a control word with bit 3 set raises `ctrl_locked`. It stays high until reset. While it is high, control-word sequences commit nothing, but clear sequences still commit.
- R9: The control word keeps only these fields: bits 4:0, bit 7, bits 12:8, bits 17:16 and bits 22:18. Every other payload bit is stored as zero.
- R10: `rd_data[31:24]` is always zero. `rd_data` bits 0 and 16 show the control word one cycle late, and the other bits show it at once.
- R11: Cycles with `wr_valid` low between the two writes of a sequence do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Key in bits 31:24, payload in bits 23:0 |
| ctrl_value | output | 24 | Committed control word |
| ctrl_locked | output | 1 | Control word frozen until reset |
| commit_ctrl | output | 1 | One-cycle pulse on a control commit |
| commit_clr | output | 1 | One-cycle pulse on a clear commit |
| wdt_clear | output | 1 | Clear request to the watchdog core |
| commit_data | output | 24 | Payload of the latest commit |
| rd_data | output | 32 | Read view of the control word |

## Verification
The checker covers several properties on every cycle:
- every commit pulse is preceded by a confirming write to the matching offset;
- the two pulses never coincide, and `wdt_clear` never appears without `commit_clr`;
- the control word changes only together with a commit;
- the lock is sticky and blocks control commits;
- undefined control bits stay zero;
- the key byte reads as zero, and the lagging readback bits follow one cycle behind.

Only the directed scenarios can show that a wrong key, a mismatched payload, a stray offset or a lone key write really aborts the sequence. The same holds for idle gaps that leave a sequence armed, and for reset releasing the lock.

// File: rtl/kg_pkg.sv
package kg_pkg;

    localparam int KEY_W  = 8;
    localparam int WORD_W = 32;
    localparam int PAY_W  = WORD_W - KEY_W;

    localparam logic [KEY_W-1:0] KEY_OPEN    = 8'h55;
    localparam logic [KEY_W-1:0] KEY_CONFIRM = 8'hAA;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_CLR  = 'h04;

    // control word field positions
    localparam int CB_EN     = 0;
    localparam int CB_DAR    = 1;
    localparam int CB_MODE   = 2;
    localparam int CB_LOCK   = 3;
    localparam int CB_IM     = 4;
    localparam int CB_FCD    = 7;
    localparam int CB_PSEL   = 8;
    localparam int PSEL_W    = 5;
    localparam int CB_CKEN   = 16;
    localparam int CB_CKSEL  = 17;
    localparam int CB_TBAN   = 18;
    localparam int TBAN_W    = 5;

    // clear word: bit 0 requests a counter restart
    localparam int CLB_KICK  = 0;

    function automatic logic [PAY_W-1:0] span(input int lo, input int w);
        logic [PAY_W-1:0] m;
        m = '0;
        for (int i = 0; i < PAY_W; i++) begin
            if (i >= lo && i < lo + w) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [PAY_W-1:0] CTRL_MASK =
          span(CB_EN, 1) | span(CB_DAR, 1) | span(CB_MODE, 1)
        | span(CB_LOCK, 1) | span(CB_IM, 1) | span(CB_FCD, 1)
        | span(CB_PSEL, PSEL_W) | span(CB_CKEN, 1) | span(CB_CKSEL, 1)
        | span(CB_TBAN, TBAN_W);

    localparam logic [PAY_W-1:0] LAG_MASK = span(CB_EN, 1) | span(CB_CKEN, 1);

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_ARM_CTRL = 2'd1,
        SEQ_ARM_CLR  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/kg_key_decode.sv
module kg_key_decode
    import kg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                fire,
    output logic                hit_ctrl,
    output logic                hit_clr,
    output logic                key_open,
    output logic                key_confirm,
    output logic [PAY_W-1:0]    payload
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);

    logic [KEY_W-1:0] key;

    always_comb begin
        key         = wr_data[WORD_W-1 -: KEY_W];
        payload     = wr_data[PAY_W-1:0];
        fire        = wr_valid;
        hit_ctrl    = (wr_addr == A_CTRL);
        hit_clr     = (wr_addr == A_CLR);
        key_open    = (key == KEY_OPEN);
        key_confirm = (key == KEY_CONFIRM);
    end

endmodule

// File: rtl/kg_seq_fsm.sv
module kg_seq_fsm
    import kg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              hit_ctrl,
    input  logic              hit_clr,
    input  logic              key_open,
    input  logic              key_confirm,
    input  logic [PAY_W-1:0]  payload,
    input  logic              locked,
    output logic              go_ctrl,
    output logic              go_clr
);

    seq_state_e        state_q, state_d;
    logic [PAY_W-1:0]  held_q;
    logic              capture;
    logic              confirm_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // captured payload of the opening write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       held_q <= '0;
        else if (capture) held_q <= payload;
    end

    // next state
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (fire) begin
                    if (hit_ctrl && key_open && !locked) begin
                        state_d = SEQ_ARM_CTRL;
                        capture = 1'b1;
                    end else if (hit_clr && key_open) begin
                        state_d = SEQ_ARM_CLR;
                        capture = 1'b1;
                    end
                end
            end
            SEQ_ARM_CTRL, SEQ_ARM_CLR: begin
                if (fire) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        confirm_ok = fire && key_confirm && (payload == held_q);
        go_ctrl    = 1'b0;
        go_clr     = 1'b0;
        unique case (state_q)
            SEQ_IDLE:     ;
            SEQ_ARM_CTRL: go_ctrl = confirm_ok && hit_ctrl && !locked;
            SEQ_ARM_CLR:  go_clr  = confirm_ok && hit_clr;
            default:      ;
        endcase
    end

endmodule

// File: rtl/kg_ctrl_store.sv
module kg_ctrl_store
    import kg_pkg::*;
#(
    parameter logic [PAY_W-1:0] RST_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_ctrl,
    input  logic [PAY_W-1:0]  payload,
    output logic [PAY_W-1:0]  ctrl_value,
    output logic              locked,
    output logic [PAY_W-1:0]  rd_view
);

    localparam logic [PAY_W-1:0] RST_CLEAN = RST_VALUE & CTRL_MASK;
    localparam logic [PAY_W-1:0] RST_LAG   = RST_CLEAN & LAG_MASK;

    logic [PAY_W-1:0] ctrl_q;
    logic [PAY_W-1:0] lag_q;
    logic             lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= RST_CLEAN;
            lock_q <= 1'b0;
        end else if (go_ctrl) begin
            ctrl_q <= payload & CTRL_MASK;
            lock_q <= lock_q | payload[CB_LOCK];
        end
    end

    // enable and clock-enable reach the read port through one stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lag_q <= RST_LAG;
        else        lag_q <= ctrl_q & LAG_MASK;
    end

    always_comb begin
        ctrl_value = ctrl_q;
        locked     = lock_q;
        rd_view    = (ctrl_q & ~LAG_MASK) | (lag_q & LAG_MASK);
    end

endmodule

// File: rtl/keyed_reg_guard.sv
module keyed_reg_guard
    import kg_pkg::*;
#(
    parameter int               ADDR_W   = 5,
    parameter logic [PAY_W-1:0] CTRL_RST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [PAY_W-1:0]    ctrl_value,
    output logic                ctrl_locked,
    output logic                commit_ctrl,
    output logic                commit_clr,
    output logic                wdt_clear,
    output logic [PAY_W-1:0]    commit_data,
    output logic [WORD_W-1:0]   rd_data
);

    logic             fire, hit_ctrl, hit_clr, key_open, key_confirm;
    logic [PAY_W-1:0] payload;
    logic             go_ctrl, go_clr;
    logic [PAY_W-1:0] rd_view;

    logic             commit_ctrl_q, commit_clr_q, wdt_clear_q;
    logic [PAY_W-1:0] commit_data_q;

    kg_key_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .fire        (fire),
        .hit_ctrl    (hit_ctrl),
        .hit_clr     (hit_clr),
        .key_open    (key_open),
        .key_confirm (key_confirm),
        .payload     (payload)
    );

    kg_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .hit_ctrl    (hit_ctrl),
        .hit_clr     (hit_clr),
        .key_open    (key_open),
        .key_confirm (key_confirm),
        .payload     (payload),
        .locked      (ctrl_locked),
        .go_ctrl     (go_ctrl),
        .go_clr      (go_clr)
    );

    kg_ctrl_store #(.RST_VALUE(CTRL_RST)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_ctrl     (go_ctrl),
        .payload     (payload),
        .ctrl_value  (ctrl_value),
        .locked      (ctrl_locked),
        .rd_view     (rd_view)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_ctrl_q <= 1'b0;
            commit_clr_q  <= 1'b0;
            wdt_clear_q   <= 1'b0;
            commit_data_q <= '0;
        end else begin
            commit_ctrl_q <= go_ctrl;
            commit_clr_q  <= go_clr;
            wdt_clear_q   <= go_clr && payload[CLB_KICK];
            if (go_ctrl)     commit_data_q <= payload & CTRL_MASK;
            else if (go_clr) commit_data_q <= payload;
        end
    end

    always_comb begin
        commit_ctrl = commit_ctrl_q;
        commit_clr  = commit_clr_q;
        wdt_clear   = wdt_clear_q;
        commit_data = commit_data_q;
        rd_data     = {{KEY_W{1'b0}}, rd_view};
    end

endmodule

// File: rtl/keyed_reg_guard_chk.sv
module keyed_reg_guard_chk
    import kg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_valid,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [WORD_W-1:0]   wr_data,
    input logic [PAY_W-1:0]    ctrl_value,
    input logic                ctrl_locked,
    input logic                commit_ctrl,
    input logic                commit_clr,
    input logic                wdt_clear,
    input logic [PAY_W-1:0]    commit_data,
    input logic [WORD_W-1:0]   rd_data
);

    assert_ctrl_after_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ctrl |-> $past(wr_valid && wr_addr == ADDR_W'(OFF_CTRL)
                              && wr_data[WORD_W-1 -: KEY_W] == KEY_CONFIRM));

    assert_ctrl_changes_only_on_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_value) |-> commit_ctrl);

    assert_pulses_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_ctrl && commit_clr));

    assert_clr_after_confirm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_clr |-> $past(wr_valid && wr_addr == ADDR_W'(OFF_CLR)
                             && wr_data[WORD_W-1 -: KEY_W] == KEY_CONFIRM));

    assert_kick_needs_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |-> (commit_clr && commit_data[CLB_KICK]));

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_locked |=> ctrl_locked);

    assert_lock_blocks_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_locked) |-> !commit_ctrl);

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_value & ~CTRL_MASK) == '0);

    assert_key_byte_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WORD_W-1 -: KEY_W] == '0);

    assert_en_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CB_EN] == $past(ctrl_value[CB_EN]));

    assert_cken_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CB_CKEN] == $past(ctrl_value[CB_CKEN]));

endmodule

bind keyed_reg_guard keyed_reg_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .ctrl_value  (ctrl_value),
    .ctrl_locked (ctrl_locked),
    .commit_ctrl (commit_ctrl),
    .commit_clr  (commit_clr),
    .wdt_clear   (wdt_clear),
    .commit_data (commit_data),
    .rd_data     (rd_data)
);

// File: tb/keyed_reg_guard_test.sv
`timescale 1ns/1ps
module keyed_reg_guard_test;

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_CLR  = 5'h04;
    localparam logic [4:0] A_STAT = 5'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [23:0] ctrl_value, commit_data;
    logic        ctrl_locked, commit_ctrl, commit_clr, wdt_clear;
    logic [31:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int seen_ctrl = 0;
    int seen_clr  = 0;

    always #2.5 clk = ~clk;

    keyed_reg_guard uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl_value(ctrl_value), .ctrl_locked(ctrl_locked),
        .commit_ctrl(commit_ctrl), .commit_clr(commit_clr), .wdt_clear(wdt_clear),
        .commit_data(commit_data), .rd_data(rd_data)
    );

    always @(negedge clk) begin
        if (commit_ctrl) seen_ctrl++;
        if (commit_clr)  seen_clr++;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] k, input logic [23:0] p);
        wr_valid = 1'b1; wr_addr = a; wr_data = {k, p};
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic quiet();
        idle(2);
        seen_ctrl = 0;
        seen_clr  = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "ctrl_value", 32'(ctrl_value), 0);
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "locked", 32'(ctrl_locked), 0);
        chk("R1", "strobes", {29'd0, commit_ctrl, commit_clr, wdt_clear}, 0);
        chk("R1", "commit_data", 32'(commit_data), 0);
    endtask

    task automatic t_ctrl_commit();
        quiet();
        wr(A_CTRL, 8'h55, 24'h011203);
        chk("R4", "pulse after opening write", 32'(commit_ctrl), 0);
        chk("R4", "ctrl after opening write", 32'(ctrl_value), 0);
        wr(A_CTRL, 8'hAA, 24'h011203);
        chk("R2", "commit_ctrl", 32'(commit_ctrl), 1);
        chk("R2", "ctrl_value", 32'(ctrl_value), 32'h011203);
        chk("R2", "commit_data", 32'(commit_data), 32'h011203);
        chk("R10", "readback lagging bits", rd_data, 32'h00001202);
        idle(1);
        chk("R2", "pulse ends", 32'(commit_ctrl), 0);
        chk("R10", "readback settled", rd_data, 32'h00011203);
    endtask

    task automatic t_clear();
        quiet();
        wr(A_CLR, 8'h55, 24'h000001);
        wr(A_CLR, 8'hAA, 24'h000001);
        chk("R3", "commit_clr", 32'(commit_clr), 1);
        chk("R3", "wdt_clear", 32'(wdt_clear), 1);
        chk("R3", "commit_data", 32'(commit_data), 1);
        chk("R3", "no ctrl pulse", 32'(commit_ctrl), 0);
        idle(1);
        chk("R3", "pulse ends", {30'd0, commit_clr, wdt_clear}, 0);
        wr(A_CLR, 8'h55, 24'h000000);
        wr(A_CLR, 8'hAA, 24'h000000);
        chk("R3", "commit with bit0 low", 32'(commit_clr), 1);
        chk("R3", "wdt_clear follows bit0", 32'(wdt_clear), 0);
        chk("R3", "ctrl untouched", 32'(ctrl_value), 32'h011203);
    endtask

    task automatic t_gap();
        quiet();
        wr(A_CLR, 8'h55, 24'h000001);
        idle(3);
        wr(A_CLR, 8'hAA, 24'h000001);
        chk("R11", "commit after idle gap", 32'(commit_clr), 1);
    endtask

    task automatic t_wrong_key();
        quiet();
        wr(A_CTRL, 8'h55, 24'h000100);
        wr(A_CTRL, 8'h12, 24'h000100);
        wr(A_CTRL, 8'hAA, 24'h000100);
        wr(A_CTRL, 8'h55, 24'h000100);
        wr(A_CTRL, 8'h55, 24'h000100);
        wr(A_CTRL, 8'hAA, 24'h000100);
        idle(1);
        chk("R5", "no commit after bad key", 32'(seen_ctrl), 0);
        chk("R5", "ctrl kept", 32'(ctrl_value), 32'h011203);
    endtask

    task automatic t_mismatch();
        quiet();
        wr(A_CTRL, 8'h55, 24'h000100);
        wr(A_CLR,  8'hAA, 24'h000100);
        wr(A_CTRL, 8'h55, 24'h000100);
        wr(A_CTRL, 8'hAA, 24'h000200);
        wr(A_CTRL, 8'h55, 24'h000100);
        wr(A_STAT, 8'hAA, 24'h000100);
        wr(A_CTRL, 8'hAA, 24'h000100);
        idle(1);
        chk("R6", "no ctrl commit", 32'(seen_ctrl), 0);
        chk("R6", "no clr commit", 32'(seen_clr), 0);
        chk("R6", "ctrl kept", 32'(ctrl_value), 32'h011203);
    endtask

    task automatic t_lone();
        quiet();
        wr(A_CTRL, 8'hAA, 24'h000100);
        wr(A_CLR,  8'hAA, 24'h000001);
        idle(1);
        chk("R7", "no commit from lone confirm", 32'(seen_ctrl + seen_clr), 0);
        chk("R7", "ctrl kept", 32'(ctrl_value), 32'h011203);
    endtask

    task automatic t_reserved();
        quiet();
        wr(A_CTRL, 8'h55, 24'hFFFFF7);
        wr(A_CTRL, 8'hAA, 24'hFFFFF7);
        chk("R9", "ctrl masked", 32'(ctrl_value), 32'h7F1F97);
        chk("R9", "commit_data masked", 32'(commit_data), 32'h7F1F97);
        idle(1);
        chk("R10", "key byte zero", rd_data, 32'h007F1F97);
        chk("R9", "not locked", 32'(ctrl_locked), 0);
    endtask

    task automatic t_lock();
        quiet();
        wr(A_CTRL, 8'h55, 24'h000008);
        wr(A_CTRL, 8'hAA, 24'h000008);
        chk("R8", "locked", 32'(ctrl_locked), 1);
        chk("R8", "ctrl with lock", 32'(ctrl_value), 32'h000008);
        quiet();
        wr(A_CTRL, 8'h55, 24'h000100);
        wr(A_CTRL, 8'hAA, 24'h000100);
        idle(1);
        chk("R8", "ctrl write ignored", 32'(seen_ctrl), 0);
        chk("R8", "ctrl frozen", 32'(ctrl_value), 32'h000008);
        wr(A_CLR, 8'h55, 24'h000001);
        wr(A_CLR, 8'hAA, 24'h000001);
        chk("R8", "clear still commits", 32'(commit_clr), 1);
        chk("R8", "still locked", 32'(ctrl_locked), 1);
        do_reset();
        chk("R8", "reset releases lock", 32'(ctrl_locked), 0);
        chk("R1", "ctrl after reset", 32'(ctrl_value), 0);
        wr(A_CTRL, 8'h55, 24'h000100);
        wr(A_CTRL, 8'hAA, 24'h000100);
        chk("R8", "ctrl writable again", 32'(ctrl_value), 32'h000100);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_ctrl_commit();
        t_clear();
        t_gap();
        t_wrong_key();
        t_mismatch();
        t_lone();
        t_reserved();
        t_lock();
        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule